// File: doc/BRIEF.md
# SPI Slave Word Transmitter with Preload

This block drives the serial output line of an SPI slave. Data leaves from a 32-bit shift register that is backed by a 32-bit holding buffer, so a stream of words goes out with no gap between them. The serial clock and the chip select come from an external master. Both are brought into the system clock domain through synchronisers, and the block detects the serial clock edges there.

The host loads the opening word while chip select is still high. That word goes straight into the shifter, so its first bit is already on the output before the master produces any clock edge. Once the frame starts, the block asks for a new word each time the holding buffer is empty. When chip select rises, the block reports how many bytes the host handed to the shifter in that frame.

Any serial clock activity while the slave is deselected counts as noise. The shifter is held clear until the clock returns to its idle level, and the opening word is then restored.

The controller has five states:
- ST_EMPTY: no word is loaded. The transition load moves to ST_ARMED.
- ST_ARMED: the opening word is in the shifter. The transition select moves to ST_ACTIVE. The transition noise moves to ST_GLITCH.
- ST_GLITCH: the shifter is cleared. The transition settle restores the opening word and moves back to ST_ARMED.
- ST_ACTIVE: the frame is shifting out. The transition deselect moves to ST_REPORT.
- ST_REPORT: the byte count is reported for one cycle. The transition done moves to ST_EMPTY.

Top module: `spi_tx_preload`

## Requirements
- R1: After reset, miso_oe, fill_req, count_valid and underrun are 0, and byte_count is 0.
- R2: A head_wr pulse while the synchronised chip select is high loads head_word into the shifter, and miso shows bit 31 of that word before any clock edge. A later head_wr, while chip select is still high, replaces the word.
- R3: miso_oe is 1 only while a frame is active. A frame is active from the synchronised chip-select fall (taken while a word is loaded) to the synchronised chip-select rise. miso_oe is 0 at all other times.
- R4: Each word leaves bit 31 first and bit 0 last. This puts the most significant byte first, and each byte most significant bit first. Consecutive words follow with no idle bit between them.
- R5: The block supports all four clock modes. The output advances on the sampled clock edge that becomes rising after the clock is inverted when cpol XOR NOT cpha is 1. With cpha=1 the first such edge of a frame does not advance the output, because the opening bit is already present.
- R6: fill_req is 1 during an active frame whenever the holding buffer is empty. A word presented with fill_valid while fill_req is 1 is accepted on that clock edge, and fill_req is 0 in the next cycle.
- R7: If the synchronised clock leaves its idle level while chip select is high and a word is loaded, miso reads 0 until the clock returns to idle. The opening word is then restored intact for the next frame.
- R8: If the holding buffer is empty when a word finishes, underrun becomes 1 and zeros are shifted out. The flag stays set until the next frame starts.
- R9: When chip select rises, count_valid pulses for exactly one cycle. byte_count then equals 4 times the number of host words moved into the shifter during the frame, including the opening word. byte_count is held until the next frame starts.
- R10: After a frame ends, a new load is needed. A chip-select fall with no head_wr leaves miso_oe and fill_req at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| sclk_in | input | 1 | Serial clock from the master, asynchronous |
| cs_n_in | input | 1 | Chip select from the master, active low, asynchronous |
| head_word | input | 32 | Opening word of the next frame |
| head_wr | input | 1 | Load strobe for head_word |
| fill_data | input | 32 | Next word for the holding buffer |
| fill_valid | input | 1 | fill_data is valid |
| fill_req | output | 1 | Holding buffer is empty during a frame |
| miso | output | 1 | Serial data, the shifter's top bit |
| miso_oe | output | 1 | Output enable for miso |
| underrun | output | 1 | A word boundary found the buffer empty |
| byte_count | output | 16 | Bytes handed to the shifter in the last frame |
| count_valid | output | 1 | One-cycle pulse when a frame ends |

## Verification
The checker watches several properties on every cycle:
- The count_valid pulse lasts one cycle.
- fill_req drops right after a word is accepted.
- fill_req never appears outside a frame.
- underrun can only rise inside a frame.
- byte_count grows only in steps of four during a frame and holds still between frames.

Some behaviours can only be shown by the bench's master model, which clocks frames in all four modes and compares every received word against its own expected stream:
- bit order and the skipped first edge in the cpha=1 modes;
- preload replacement and glitch recovery;
- the zero fill after an underrun;
- the exact byte totals.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_ARMED,
        ST_GLITCH,
        ST_ACTIVE,
        ST_REPORT
    } tx_state_e;
endpackage

// File: rtl/spi_tx_sync.sv
module spi_tx_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_tx_edge.sv
module spi_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic act_edge,
    output logic at_idle
);
    logic phase;
    logic phase_q;

    // shifting edge becomes rising after optional inversion
    assign phase = sclk_s ^ (cpol ^ ~cpha);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b1;
        else        phase_q <= phase;
    end

    assign act_edge = phase & ~phase_q;
    assign at_idle  = (sclk_s == cpol);
endmodule

// File: rtl/spi_tx_preload.sv
module spi_tx_preload
    import spi_tx_pkg::*;
#(
    parameter int W           = 32,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             sclk_in,
    input  logic             cs_n_in,
    input  logic [W-1:0]     head_word,
    input  logic             head_wr,
    input  logic [W-1:0]     fill_data,
    input  logic             fill_valid,
    output logic             fill_req,
    output logic             miso,
    output logic             miso_oe,
    output logic             underrun,
    output logic [CNT_W-1:0] byte_count,
    output logic             count_valid
);
    localparam int            BYTES = W / 8;
    localparam int            BW    = $clog2(W);
    localparam logic [BW-1:0] LAST  = BW'(W - 1);

    tx_state_e state_q, state_d;

    logic             cs_s, sclk_s, act_edge, at_idle;
    logic [W-1:0]     shift_q, head_q, buf_q;
    logic             buf_full_q;
    logic [BW-1:0]    bit_q;
    logic             skip_q;
    logic [CNT_W-1:0] count_q;
    logic             under_q;
    logic             head_take, take_fill, shift_ev, word_end;

    spi_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n_in), .q(cs_s)
    );

    spi_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sclk_s)
    );

    spi_tx_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cpol(cpol), .cpha(cpha),
        .act_edge(act_edge), .at_idle(at_idle)
    );

    assign head_take = head_wr && cs_s &&
                       ((state_q == ST_EMPTY) || (state_q == ST_ARMED));
    assign take_fill = fill_req && fill_valid;
    assign shift_ev  = (state_q == ST_ACTIVE) && !cs_s && act_edge;
    assign word_end  = shift_ev && !skip_q && (bit_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (head_take) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!cs_s)         state_d = ST_ACTIVE;
                else if (!at_idle) state_d = ST_GLITCH;
            end
            ST_GLITCH: if (at_idle) state_d = ST_ARMED;
            ST_ACTIVE: if (cs_s)    state_d = ST_REPORT;
            ST_REPORT: state_d = ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // datapath: shifter, holding buffer, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            head_q     <= '0;
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            bit_q      <= '0;
            skip_q     <= 1'b0;
            count_q    <= '0;
            under_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_EMPTY, ST_ARMED: begin
                    if (head_take) begin
                        head_q  <= head_word;
                        shift_q <= head_word;
                    end
                    if ((state_q == ST_ARMED) && !cs_s) begin
                        count_q    <= CNT_W'(BYTES);
                        under_q    <= 1'b0;
                        buf_full_q <= 1'b0;
                        bit_q      <= '0;
                        skip_q     <= cpha;
                    end
                end
                ST_GLITCH: begin
                    shift_q <= at_idle ? head_q : '0;
                    bit_q   <= '0;
                end
                ST_ACTIVE: begin
                    if (shift_ev) begin
                        if (skip_q) begin
                            skip_q <= 1'b0;
                        end else if (word_end) begin
                            bit_q <= '0;
                            if (buf_full_q) begin
                                shift_q <= buf_q;
                                count_q <= count_q + CNT_W'(BYTES);
                            end else begin
                                shift_q <= '0;
                                under_q <= 1'b1;
                            end
                        end else begin
                            shift_q <= {shift_q[W-2:0], 1'b0};
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                    if (take_fill) begin
                        buf_q      <= fill_data;
                        buf_full_q <= 1'b1;
                    end else if (word_end && buf_full_q) begin
                        buf_full_q <= 1'b0;
                    end
                end
                ST_REPORT: buf_full_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        miso_oe     = 1'b0;
        fill_req    = 1'b0;
        count_valid = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                miso_oe  = 1'b1;
                fill_req = !buf_full_q;
            end
            ST_REPORT: count_valid = 1'b1;
            default: ;
        endcase
    end

    assign miso       = shift_q[W-1];
    assign underrun   = under_q;
    assign byte_count = count_q;
endmodule

// File: rtl/spi_tx_preload_chk.sv
module spi_tx_preload_chk #(
    parameter int W     = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_req,
    input logic             fill_valid,
    input logic             miso_oe,
    input logic             underrun,
    input logic [CNT_W-1:0] byte_count,
    input logic             count_valid
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(W / 8);

    // R9
    report_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |=> !count_valid);

    // R6
    fill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |=> !fill_req);

    // R6
    fill_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> miso_oe);

    // R8
    underrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> miso_oe);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe)) |->
            ((byte_count == $past(byte_count)) ||
             (byte_count == $past(byte_count) + STEP)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |=> (miso_oe || $stable(byte_count)));
endmodule

bind spi_tx_preload spi_tx_preload_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_valid(fill_valid),
    .miso_oe(miso_oe), .underrun(underrun), .byte_count(byte_count),
    .count_valid(count_valid)
);

// File: tb/tb_spi_tx_preload.sv
`timescale 1ns/1ps
module tb_spi_tx_preload;
    localparam int W = 32, CNT_W = 16, HALF = 8;

    logic clk = 0, rst_n = 0, cpol = 0, cpha = 0, sclk_in = 0, cs_n_in = 1;
    logic head_wr = 0, fill_valid = 0;
    logic [W-1:0] head_word = '0, fill_data = '0;
    logic fill_req, miso, miso_oe, underrun, count_valid;
    logic [CNT_W-1:0] byte_count;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [W-1:0] wq [5];
    int sup_n = 0, sup_idx = 0;

    always #2.5 clk = ~clk;

    spi_tx_preload dut (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sclk_in(sclk_in),
        .cs_n_in(cs_n_in), .head_word(head_word), .head_wr(head_wr),
        .fill_data(fill_data), .fill_valid(fill_valid), .fill_req(fill_req),
        .miso(miso), .miso_oe(miso_oe), .underrun(underrun),
        .byte_count(byte_count), .count_valid(count_valid)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_word(int w, int sup);
        if (w == 0)   return wq[0];
        if (w <= sup) return wq[w];
        return 32'h0;
    endfunction

    function automatic int exp_count(bit ch, int k, int sup);
        int ends = ch ? k - 1 : k;
        return 4 * (1 + ((ends < sup) ? ends : sup));
    endfunction

    // host model answering refill requests
    initial begin
        forever begin
            @(negedge clk);
            if (fill_valid) fill_valid = 0;
            else if (fill_req && sup_idx < sup_n) begin
                sup_idx++;
                fill_data  = wq[sup_idx];
                fill_valid = 1;
            end
        end
    end

    task automatic set_mode(bit cp, bit ch);
        cpol = cp; cpha = ch; sclk_in = cp;
        tick(6);
    endtask

    task automatic preload(logic [W-1:0] w);
        @(negedge clk); head_word = w; head_wr = 1;
        @(negedge clk); head_wr = 0;
        tick(2);
    endtask

    task automatic run_frame(int k, int sup, string tag);
        logic [31:0] got;
        bit seen;
        int ends;
        sup_n = sup; sup_idx = 0;
        chk({tag, " R3 oe before select"}, miso_oe, 0);
        cs_n_in = 0;
        tick(HALF);
        chk({tag, " R3 oe in frame"}, miso_oe, 1);
        chk({tag, " R6 refill request"}, fill_req, (sup == 0));
        for (int w = 0; w < k; w++) begin
            got = 0;
            for (int b = 0; b < 32; b++) begin
                if (!cpha) got = {got[30:0], miso};
                sclk_in = ~cpol; tick(HALF);
                if (cpha) got = {got[30:0], miso};
                sclk_in = cpol; tick(HALF);
            end
            chk({tag, " R4 R5 word"}, got, exp_word(w, sup));
        end
        cs_n_in = 1;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (count_valid) begin seen = 1; break; end
        end
        chk({tag, " R9 report pulse"}, seen, 1);
        tick(2);
        chk({tag, " R9 byte count"}, byte_count, exp_count(cpha, k, sup));
        ends = cpha ? k - 1 : k;
        chk({tag, " R8 underrun flag"}, underrun, (ends > sup));
        chk({tag, " R3 oe after frame"}, miso_oe, 0);
        sup_n = 0;
        tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tick(4);
        rst_n = 1;
        tick(2);
        // R1
        chk("R1 oe", miso_oe, 0);
        chk("R1 fill_req", fill_req, 0);
        chk("R1 count_valid", count_valid, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 byte_count", byte_count, 0);

        // R2: load, then replace while deselected
        set_mode(0, 0);
        preload(32'h1234_5678);
        chk("R2 first load msb", miso, 0);
        wq[0] = 32'h8123_4567; wq[1] = 32'hA5C3_0F81; wq[2] = 32'h0F0F_F0F0;
        preload(wq[0]);
        chk("R2 replaced msb", miso, 1);
        run_frame(2, 2, "R2");

        // R7: clock noise while deselected
        wq[0] = 32'hF00D_BEEF; wq[1] = 32'h1357_9BDF;
        preload(wq[0]);
        sclk_in = 1; tick(6);
        chk("R7 cleared during noise", miso, 0);
        sclk_in = 0; tick(6);
        chk("R7 restored after noise", miso, 1);
        run_frame(1, 1, "R7");

        // R8: no refill supplied
        wq[0] = $urandom();
        preload(wq[0]);
        run_frame(2, 0, "R8");

        // R10: select without a new load
        cs_n_in = 0; tick(10);
        chk("R10 oe stays low", miso_oe, 0);
        chk("R10 no refill request", fill_req, 0);
        cs_n_in = 1; tick(6);

        // R5: each mode once, then random frames
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            for (int j = 0; j < 5; j++) wq[j] = $urandom();
            preload(wq[0]);
            run_frame(2, 2, "R5 mode");
        end
        for (int f = 0; f < 8; f++) begin
            int k;
            set_mode($urandom() % 2 == 1, $urandom() % 2 == 1);
            k = 1 + ($urandom() % 3);
            for (int j = 0; j < 5; j++) wq[j] = $urandom();
            preload(wq[0]);
            run_frame(k, k, "R6 random");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule